// File: doc/BRIEF.md
# DRAM Bank State and Power-Mode Tracker

This block listens to the decoded command stream going to a four-bank DDR2-style memory. For each bank it keeps one of two named states, IDLE (no open row) or ACTIVE (a row is open), and it holds the row address of the last successful activate to that bank. The clock-enable input drives a power-mode state machine with four named states. NORMAL accepts commands. PDPRE is precharge power-down, entered when clock enable drops with all banks idle. PDACT is active power-down, entered when clock enable drops with at least one row open. SREF is self-refresh, entered when a refresh is issued in the same cycle that clock enable drops.

The tracker raises a one-cycle illegal flag for protocol misuse. The cases are: an activate to a bank that already has an open row, a read or write to an idle bank, clock enable dropped while a read or write burst is still running, and a self-refresh request while a row is open. A controller or a monitor can read the bank and power outputs to decide which commands may follow.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset, every bank is IDLE, every row output is zero, the power mode is NORMAL (0) and the illegal flag is low.
- R2: Commands are accepted only in NORMAL with clock enable high. An accepted activate to an IDLE bank moves that bank to ACTIVE and records the row input, visible after the next clock edge.
- R3: A command sampled with chip select high (cs_n = 1) changes no bank state, no row and no burst.
- R4: An accepted precharge with a10 = 0 closes only the bank on ba. With a10 = 1 it closes all banks. Rows keep their last value.
- R5: An activate to an ACTIVE bank, or a read or write to an IDLE bank, raises the illegal flag for one cycle and leaves bank state and row unchanged.
- R6: In NORMAL, clock enable sampled low without a refresh command moves the mode to PDACT (2) if any bank is ACTIVE and to PDPRE (1) otherwise. In either power-down state, clock enable sampled high returns the mode to NORMAL. No command is accepted outside NORMAL.
- R7: In NORMAL, a refresh command (cs_n = 0) sampled with clock enable low moves the mode to SREF (3) if all banks are IDLE. If any bank is ACTIVE, it instead raises the illegal flag and enters PDACT.
- R8: In SREF, the power-mode output reads NORMAL as soon as clock enable is high, with no clock edge needed. The state machine leaves SREF at the next edge.
- R9: An accepted read or write to an ACTIVE bank starts a burst of BURST_CYC cycles. Clock enable sampled low in NORMAL during the next BURST_CYC edges raises the illegal flag.
- R10: The command code is {ras_n, cas_n, we_n}: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode-register set, 111 no-operation. The codes 000, 110 and 111 do not affect bank state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| cmd | input | 3 | Command code {ras_n, cas_n, we_n} |
| ba | input | BA_W (2) | Bank address |
| a10 | input | 1 | Precharge-all select |
| row | input | ROW_W (14) | Row address for activate |
| cke | input | 1 | Clock enable |
| bank_open | output | NUM_BANKS (4) | One bit per bank, 1 = ACTIVE |
| open_rows | output | NUM_BANKS*ROW_W | Recorded row per bank, bank 0 in the low bits |
| power_mode | output | 2 | 0 NORMAL, 1 PDPRE, 2 PDACT, 3 SREF |
| illegal | output | 1 | One-cycle protocol-violation pulse |

## Verification
The bench targets the boundaries where a faulty tracker would go wrong in visible ways. One is precharge with a10 low against a10 high: a design that ignored a10 would close every bank or only one. Another is the choice of power-down kind: a design that checked occupancy after applying a command would pick PDPRE with a row still open. Dropping clock enable on the last burst edge and one edge later probes the burst window, where an off-by-one counter would flag too early or miss the violation. Raising clock enable in SREF is checked before the next clock edge, so a purely registered exit would show SREF for one extra half cycle.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_BST = 3'b110,
        CMD_NOP = 3'b111
    } cmd_t;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_PDPRE  = 2'd1,
        PM_PDACT  = 2'd2,
        PM_SREF   = 2'd3
    } pmode_t;

    typedef enum logic {
        BK_IDLE   = 1'b0,
        BK_ACTIVE = 1'b1
    } bank_st_t;

endpackage

// File: rtl/dbt_cmd_decode.sv
module dbt_cmd_decode
    import dbt_pkg::*;
(
    input  logic       cs_n,
    input  logic [2:0] cmd_raw,
    output logic       is_act,
    output logic       is_rdwr,
    output logic       is_pre,
    output logic       is_ref
);

    cmd_t code;

    always_comb begin
        code    = cmd_t'(cmd_raw);
        is_act  = 1'b0;
        is_rdwr = 1'b0;
        is_pre  = 1'b0;
        is_ref  = 1'b0;
        if (!cs_n) begin
            unique case (code)
                CMD_ACT:         is_act  = 1'b1;
                CMD_RD, CMD_WR:  is_rdwr = 1'b1;
                CMD_PRE:         is_pre  = 1'b1;
                CMD_REF:         is_ref  = 1'b1;
                CMD_MRS, CMD_BST, CMD_NOP: ;
            endcase
        end
    end

endmodule

// File: rtl/dbt_bank.sv
module dbt_bank
    import dbt_pkg::*;
#(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_req,
    input  logic             close_req,
    input  logic [ROW_W-1:0] row_in,
    output logic             is_open,
    output logic [ROW_W-1:0] row_q
);

    bank_st_t st_q, st_d;
    logic [ROW_W-1:0] row_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            row_q <= '0;
        end else begin
            st_q  <= st_d;
            row_q <= row_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        row_d = row_q;
        unique case (st_q)
            BK_IDLE: if (open_req) begin
                st_d  = BK_ACTIVE;
                row_d = row_in;
            end
            BK_ACTIVE: if (close_req) st_d = BK_IDLE;
        endcase
    end

    always_comb is_open = (st_q == BK_ACTIVE);

    // R2
    open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_req |=> (is_open && row_q == $past(row_in)));

    // R4
    close_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_req |=> !is_open);

endmodule

// File: rtl/dbt_power_fsm.sv
module dbt_power_fsm
    import dbt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cke,
    input  logic   sref_req,
    input  logic   any_open,
    output pmode_t mode_q,
    output pmode_t mode_out,
    output logic   cmd_window,
    output logic   sref_bad
);

    pmode_t mode_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= PM_NORMAL;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d   = mode_q;
        sref_bad = 1'b0;
        unique case (mode_q)
            PM_NORMAL: if (!cke) begin
                if (sref_req) begin
                    if (any_open) begin
                        sref_bad = 1'b1;
                        mode_d   = PM_PDACT;
                    end else begin
                        mode_d   = PM_SREF;
                    end
                end else begin
                    mode_d = any_open ? PM_PDACT : PM_PDPRE;
                end
            end
            PM_PDPRE, PM_PDACT: if (cke) mode_d = PM_NORMAL;
            PM_SREF:            if (cke) mode_d = PM_NORMAL;
        endcase
    end

    always_comb begin
        mode_out   = (mode_q == PM_SREF && cke) ? PM_NORMAL : mode_q;
        cmd_window = (mode_q == PM_NORMAL) && cke;
    end

    // R6
    pd_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == PM_PDPRE || mode_q == PM_PDACT) && cke) |=> mode_q == PM_NORMAL);

    // R6
    pd_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_NORMAL && !cke && !sref_req)
        |=> mode_q == ($past(any_open) ? PM_PDACT : PM_PDPRE));

    // R7
    sref_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_NORMAL && !cke && sref_req)
        |=> ((mode_q == PM_SREF) == !$past(any_open)));

endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
    import dbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 14,
    parameter int BURST_CYC = 4,
    localparam int BA_W     = $clog2(NUM_BANKS),
    localparam int BC_W     = $clog2(BURST_CYC + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic [2:0]                 cmd,
    input  logic [BA_W-1:0]            ba,
    input  logic                       a10,
    input  logic [ROW_W-1:0]           row,
    input  logic                       cke,
    output logic [NUM_BANKS-1:0]       bank_open,
    output logic [NUM_BANKS*ROW_W-1:0] open_rows,
    output logic [1:0]                 power_mode,
    output logic                       illegal
);

    logic is_act, is_rdwr, is_pre, is_ref;
    logic any_open, cmd_window, sref_bad;
    logic sel_open, act_bad, rdwr_bad, rdwr_ok, burst_drop;
    logic [BC_W-1:0] burst_q;
    logic burst_busy;
    pmode_t mode_q, mode_out;

    dbt_cmd_decode u_dec (
        .cs_n    (cs_n),
        .cmd_raw (cmd),
        .is_act  (is_act),
        .is_rdwr (is_rdwr),
        .is_pre  (is_pre),
        .is_ref  (is_ref)
    );

    always_comb begin
        any_open   = |bank_open;
        sel_open   = bank_open[ba];
        act_bad    = cmd_window && is_act && sel_open;
        rdwr_bad   = cmd_window && is_rdwr && !sel_open;
        rdwr_ok    = cmd_window && is_rdwr && sel_open;
        burst_busy = (burst_q != '0);
        burst_drop = (mode_q == PM_NORMAL) && !cke && burst_busy;
    end

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit;
        always_comb hit = (ba == BA_W'(i));
        dbt_bank #(.ROW_W(ROW_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .open_req  (cmd_window && is_act && hit && !bank_open[i]),
            .close_req (cmd_window && is_pre && (a10 || hit)),
            .row_in    (row),
            .is_open   (bank_open[i]),
            .row_q     (open_rows[i*ROW_W +: ROW_W])
        );
    end

    dbt_power_fsm u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .cke        (cke),
        .sref_req   (is_ref),
        .any_open   (any_open),
        .mode_q     (mode_q),
        .mode_out   (mode_out),
        .cmd_window (cmd_window),
        .sref_bad   (sref_bad)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_q <= '0;
            illegal <= 1'b0;
        end else begin
            if (rdwr_ok)         burst_q <= BC_W'(BURST_CYC);
            else if (burst_busy) burst_q <= burst_q - 1'b1;
            illegal <= act_bad || rdwr_bad || burst_drop || sref_bad;
        end
    end

    always_comb power_mode = mode_out;

    // R3
    cs_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(bank_open) && $stable(open_rows)));

    // R9
    burst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PM_NORMAL && !cke && burst_busy) |=> illegal);

    // R5
    act_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_window && is_act && sel_open) |=> (illegal && $stable(open_rows)));

endmodule

// File: tb/dram_bank_tracker_tb.sv
`timescale 1ns/1ps
module dram_bank_tracker_tb;

    localparam int NB = 4;
    localparam int RW = 14;
    localparam int BC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic [2:0] cmd = 3'b111;
    logic [1:0] ba = '0;
    logic a10 = 1'b0;
    logic [RW-1:0] row = '0;
    logic cke = 1'b1;
    logic [NB-1:0] bank_open;
    logic [NB*RW-1:0] open_rows;
    logic [1:0] power_mode;
    logic illegal;

    int tests = 0;
    int fails = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    dram_bank_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .BURST_CYC(BC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd(cmd), .ba(ba), .a10(a10),
        .row(row), .cke(cke), .bank_open(bank_open), .open_rows(open_rows),
        .power_mode(power_mode), .illegal(illegal)
    );

    // Behavioural reference model
    bit m_open [NB];
    int m_row  [NB];
    int m_mode;
    int m_cnt;
    bit m_ill;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_open[k]) begin m_open[k] = 0; m_row[k] = 0; end
            m_mode = 0; m_cnt = 0; m_ill = 0;
        end else begin
            bit any, ill, load;
            any = 0; ill = 0; load = 0;
            foreach (m_open[k]) if (m_open[k]) any = 1;
            if (m_mode == 0 && cke && !cs_n) begin
                case (cmd)
                    3'b011: if (m_open[ba]) ill = 1;
                            else begin m_open[ba] = 1; m_row[ba] = int'(row); end
                    3'b101, 3'b100: if (!m_open[ba]) ill = 1; else load = 1;
                    3'b010: if (a10) foreach (m_open[k]) m_open[k] = 0;
                            else m_open[ba] = 0;
                    default: ;
                endcase
            end
            if (m_mode == 0 && !cke && m_cnt != 0) ill = 1;
            if (load) m_cnt = BC; else if (m_cnt > 0) m_cnt = m_cnt - 1;
            case (m_mode)
                0: if (!cke) begin
                       if (!cs_n && cmd == 3'b001) begin
                           if (any) begin ill = 1; m_mode = 2; end else m_mode = 3;
                       end else m_mode = any ? 2 : 1;
                   end
                default: if (cke) m_mode = 0;
            endcase
            m_ill = ill;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (phase %s) t=%0t actual=%h expected=%h", tag, phase, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [NB-1:0] eo;
        logic [NB*RW-1:0] er;
        int em;
        #2;
        for (int k = 0; k < NB; k++) begin
            eo[k] = m_open[k];
            er[k*RW +: RW] = RW'(m_row[k]);
        end
        em = (m_mode == 3 && cke) ? 0 : m_mode;
        check("R2 bank_open", 64'(bank_open), 64'(eo));
        check("R4 open_rows", 64'(open_rows), 64'(er));
        check("R6 power_mode", 64'(power_mode), 64'(em));
        check("R5 illegal", 64'(illegal), 64'(m_ill));
    end

    task automatic step(input logic c, input logic [2:0] op, input logic [1:0] b,
                        input logic a, input logic [RW-1:0] r, input logic k);
        @(negedge clk);
        cs_n = c; cmd = op; ba = b; a10 = a; row = r; cke = k;
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 3'b111, 2'd0, 1'b0, '0, 1'b1);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        nop(2);
        phase = "R2"; // activate records rows
        step(0, 3'b011, 2'd0, 0, 14'h1234, 1);
        step(0, 3'b011, 2'd2, 0, 14'h3FFF, 1);
        nop(1);
        phase = "R3"; // commands with chip select high
        step(1, 3'b011, 2'd1, 0, 14'h0AAA, 1);
        step(1, 3'b010, 2'd0, 1, '0, 1);
        step(1, 3'b101, 2'd0, 0, '0, 1);
        nop(1);
        phase = "R5"; // illegal commands
        step(0, 3'b011, 2'd0, 0, 14'h0555, 1);
        step(0, 3'b101, 2'd1, 0, '0, 1);
        step(0, 3'b100, 2'd3, 0, '0, 1);
        nop(1);
        phase = "R9"; // drop cke during burst
        step(0, 3'b101, 2'd0, 0, '0, 1);
        step(0, 3'b111, 2'd0, 0, '0, 0);
        step(0, 3'b011, 2'd1, 0, 14'h0777, 0);
        step(0, 3'b111, 2'd0, 0, '0, 1);
        nop(6);
        step(0, 3'b100, 2'd2, 0, '0, 1);
        nop(BC - 1);
        step(0, 3'b111, 2'd0, 0, '0, 0);
        step(0, 3'b111, 2'd0, 0, '0, 1);
        nop(1);
        step(0, 3'b100, 2'd2, 0, '0, 1);
        nop(BC);
        step(0, 3'b111, 2'd0, 0, '0, 0);
        step(0, 3'b111, 2'd0, 0, '0, 1);
        nop(2);
        phase = "R4"; // single and all-bank precharge
        step(0, 3'b010, 2'd0, 0, '0, 1);
        step(0, 3'b011, 2'd1, 0, 14'h0123, 1);
        nop(1);
        step(0, 3'b010, 2'd3, 1, '0, 1);
        nop(1);
        phase = "R6"; // power-down kinds
        step(0, 3'b111, 2'd0, 0, '0, 0);
        step(0, 3'b111, 2'd0, 0, '0, 0);
        step(0, 3'b111, 2'd0, 0, '0, 1);
        step(0, 3'b011, 2'd3, 0, 14'h2222, 1);
        step(0, 3'b111, 2'd0, 0, '0, 0);
        step(0, 3'b010, 2'd3, 1, '0, 0);
        step(0, 3'b111, 2'd0, 0, '0, 1);
        step(0, 3'b010, 2'd0, 1, '0, 1);
        nop(1);
        phase = "R7"; // self-refresh entry
        step(0, 3'b001, 2'd0, 0, '0, 0);
        step(1, 3'b111, 2'd0, 0, '0, 0);
        step(1, 3'b111, 2'd0, 0, '0, 0);
        phase = "R8"; // asynchronous self-refresh exit
        step(0, 3'b111, 2'd0, 0, '0, 1);
        nop(2);
        phase = "R7";
        step(0, 3'b011, 2'd1, 0, 14'h1111, 1);
        step(0, 3'b001, 2'd0, 0, '0, 0);
        step(0, 3'b111, 2'd0, 0, '0, 1);
        phase = "R10"; // non-bank codes
        step(0, 3'b000, 2'd1, 1, '0, 1);
        step(0, 3'b110, 2'd1, 1, '0, 1);
        step(0, 3'b001, 2'd1, 1, '0, 1);
        step(0, 3'b010, 2'd0, 1, '0, 1);
        nop(2);
        phase = "random";
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 10) == 0, 3'($urandom), 2'($urandom), 1'($urandom % 4 == 0),
                 RW'($urandom), ($urandom % 8) != 0);
        end
        phase = "R1";
        @(negedge clk); rst_n = 1'b0;
        nop(2);
        rst_n = 1'b1;
        nop(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule